// File: doc/BRIEF.md
# Programmable Skew Clock Bank Generator

This block derives four banks of paired clock outputs from a reference clock. The reference is sampled in a fast timing-clock domain. Each output is a copy of the reference, delayed by a whole number of fast cycles. Delays are counted in timing units (tU). One tU is a parameterised number of fast cycles, and a three-level range input picks which of three lengths applies.

Three of the banks are programmable. Each has a pair of three-level select inputs that choose one of nine taps. The first two banks step in single tU. The third steps in two tU, and its two extreme codes turn it into a divide-by-2 or divide-by-4 output. The fourth bank is fixed. Every output carries a common base latency of 6 tU, and a lead (negative skew) is obtained by subtracting from that base, so no output moves before the reference edge it copies. Selects and range are captured only on a reference rising edge.

Top module: `prog_skew_clkgen`

## Requirements
- R1: Each three-level input is coded on two bits: 2'b00 LOW, 2'b01 MID, 2'b10 HIGH. The undriven code 2'b11 is read as MID. A bank select is {first, second} three-level inputs, with the first in bits [3:2].
- R2: For banks 1 and 2, the select pairs LL, LM, LH, ML, MM, MH, HL, HM, HH give skews of -4 to +4 tU in unit steps. The rising edge appears (6 + skew) × tU fast cycles after the reference rise is sampled.
- R3: For bank 3 in delay mode, LM, LH, ML, MM, MH, HL, HM give -6, -4, -2, 0, +2, +4, +6 tU with the same (6 + skew) × tU latency.
- R4: Bank 3 with select LL outputs half the reference rate. It toggles exactly 6 tU after each sampled reference rise, so it rises on every second reference pulse.
- R5: Bank 3 with select HH outputs a quarter of the reference rate, rising on every fourth reference pulse at 6 tU.
- R6: Bank 4 always follows the reference with a latency of exactly 6 tU.
- R7: One tU is TU_LOW, TU_MID or TU_HIGH fast cycles (defaults 4, 3, 2) for the range codes LOW, MID and HIGH.
- R8: The two outputs of each bank are identical at all times.
- R9: New select and range values take effect only at a sampled reference rising edge. A change made during a pulse leaves that pulse's rising and falling timing unchanged.
- R10: While rst_n is low, all outputs are low, whatever the reference does.
- R11: A falling edge of the reference is delayed by the same amount as the rising edge, so the pulse width is preserved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast timing clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_in | input | 1 | Reference clock, sampled on clk |
| range_sel | input | 2 | Three-level tU range select |
| bank1_sel | input | 4 | Bank 1 tap select, two three-level inputs |
| bank2_sel | input | 4 | Bank 2 tap select |
| bank3_sel | input | 4 | Bank 3 tap or divide select |
| q1 | output | 2 | Bank 1 output pair |
| q2 | output | 2 | Bank 2 output pair |
| q3 | output | 2 | Bank 3 output pair |
| q4 | output | 2 | Bank 4 output pair, fixed latency |

## Verification
Every result is timed from the clock edge that first samples a reference rise. A bank whose delay is D cycles shows its rise in the sample taken D cycles after that edge. Its fall shows D cycles after the edge that samples the reference fall. Divided outputs change exactly 6 tU after a sampled rise. The bench drives the reference on falling clock edges and counts outputs on the falling edges that follow. It records the index of the first high and the first low sample for each output and compares those indices with the expected latencies. Select changes are applied between edges, so the checks can show that the pulse already in flight keeps the old timing and the next pulse takes the new timing.

// File: rtl/skew_pkg.sv
// Shared types and helpers for the programmable skew clock bank generator.
// Assumes three-level inputs arrive as two-bit codes; code 2'b11 means undriven.
package skew_pkg;

    localparam int BASE_TU = 6;   // common base latency in timing units

    typedef enum logic [1:0] {
        MODE_DELAY = 2'd0,
        MODE_DIV2  = 2'd1,
        MODE_DIV4  = 2'd2
    } bank_mode_e;

    // Map a two-bit three-level code to 0 (LOW), 1 (MID) or 2 (HIGH).
    function automatic int unsigned level_of(input logic [1:0] code);
        case (code)
            2'b00:   return 0;
            2'b10:   return 2;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/skew_tap_decode.sv
// Tap decoder for one bank: converts a pair of three-level selects into a
// delay in fast cycles and a mode. WIDE selects the two-tU step with divide
// codes at the table ends. Purely combinational; tu is the current tU length.
module skew_tap_decode
    import skew_pkg::*;
#(
    parameter bit WIDE = 1'b0,
    parameter int TW   = 3,
    parameter int DW   = 6
) (
    input  logic [3:0]    sel,
    input  logic [TW-1:0] tu,
    output logic [DW-1:0] dly,
    output bank_mode_e    mode
);

    int unsigned idx;
    int unsigned mult;

    // Select index 0..8 to a multiple of tU, base latency included.
    always_comb begin
        idx  = 3 * level_of(sel[3:2]) + level_of(sel[1:0]);
        mode = MODE_DELAY;
        if (WIDE) begin
            mult = (idx == 0 || idx == 8) ? BASE_TU : 2 * idx - 2;
            if (idx == 0) mode = MODE_DIV2;
            if (idx == 8) mode = MODE_DIV4;
        end else begin
            mult = idx + 2;
        end
        dly = DW'(mult * int'(tu));
    end

endmodule

// File: rtl/skew_delay_line.sv
// Sampled delay line: taps[k] holds the reference as it was k+1 fast cycles ago.
// Assumes DEPTH covers the largest selectable delay.
module skew_delay_line #(
    parameter int DEPTH = 49
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    output logic [DEPTH-1:0] taps
);

    // Shift one new reference sample in per fast cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) taps <= '0;
        else        taps <= {taps[DEPTH-2:0], din};
    end

endmodule

// File: rtl/skew_divider.sv
// Two-bit edge counter for the divided bank. It advances once per tick, where
// a tick marks a base-delayed reference rise. Bit 0 gives /2 and bit 1 gives /4.
module skew_divider (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic [1:0] cnt
);

    // Count base-delayed reference rises.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= 2'd0;
        else if (tick) cnt <= cnt + 2'd1;
    end

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(cnt)); // R4
    AST_DIV_STEP: assert property (@(posedge clk) disable iff (!rst_n) tick |=> cnt == $past(cnt) + 2'd1); // R5

endmodule

// File: rtl/prog_skew_clkgen.sv
// Programmable skew clock bank generator. Samples ref_in on clk, delays it
// through a tapped line, and drives four output pairs with per-bank delays of
// (6 + skew) tU. Selects and range are captured on each sampled reference rise.
// Assumes the reference stays low longer than the largest delay.
module prog_skew_clkgen
    import skew_pkg::*;
#(
    parameter int TU_LOW  = 4,
    parameter int TU_MID  = 3,
    parameter int TU_HIGH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    input  logic [1:0] range_sel,
    input  logic [3:0] bank1_sel,
    input  logic [3:0] bank2_sel,
    input  logic [3:0] bank3_sel,
    output logic [1:0] q1,
    output logic [1:0] q2,
    output logic [1:0] q3,
    output logic [1:0] q4
);

    localparam int TU_MAX  = (TU_LOW > TU_MID) ? ((TU_LOW > TU_HIGH) ? TU_LOW : TU_HIGH)
                                               : ((TU_MID > TU_HIGH) ? TU_MID : TU_HIGH);
    localparam int TW      = $clog2(TU_MAX + 1);
    localparam int MAX_DLY = 2 * BASE_TU * TU_MAX;
    localparam int DEPTH   = MAX_DLY + 1;
    localparam int DW      = $clog2(DEPTH);
    localparam int NBANK   = 3;

    logic [DEPTH-1:0]       taps;
    logic                   ref_rise;
    logic [1:0]             rng_q;
    logic [NBANK-1:0][3:0]  sel_q;
    logic [TW-1:0]          tu;
    logic [DW-1:0]          base;
    logic [NBANK-1:0][DW-1:0] dly;
    bank_mode_e             mode [NBANK];
    logic [NBANK-1:0]       raw;
    logic                   tick;
    logic [1:0]             div_cnt;
    logic                   b3_out;

    skew_delay_line #(.DEPTH(DEPTH)) i_line (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_in),
        .taps (taps)
    );

    assign ref_rise = ref_in & ~taps[0];

    // Capture selects and range on a sampled reference rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rng_q <= 2'b01;
            sel_q <= {NBANK{4'b0101}};
        end else if (ref_rise) begin
            rng_q <= range_sel;
            sel_q <= {bank3_sel, bank2_sel, bank1_sel};
        end
    end

    // Length of one timing unit for the captured range.
    always_comb begin
        case (level_of(rng_q))
            0:       tu = TW'(TU_LOW);
            2:       tu = TW'(TU_HIGH);
            default: tu = TW'(TU_MID);
        endcase
        base = DW'(BASE_TU * int'(tu));
    end

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            skew_tap_decode #(.WIDE(b == NBANK - 1), .TW(TW), .DW(DW)) i_dec (
                .sel (sel_q[b]),
                .tu  (tu),
                .dly (dly[b]),
                .mode(mode[b])
            );
            assign raw[b] = taps[dly[b]];
        end
    endgenerate

    assign tick = taps[base - DW'(1)] & ~taps[base];

    skew_divider i_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .cnt  (div_cnt)
    );

    // Bank 3 output: delayed tap or one of the divided phases.
    always_comb begin
        case (mode[NBANK-1])
            MODE_DIV2: b3_out = div_cnt[0];
            MODE_DIV4: b3_out = div_cnt[1];
            default:   b3_out = raw[NBANK-1];
        endcase
    end

    assign q1 = {2{raw[0]}};
    assign q2 = {2{raw[1]}};
    assign q3 = {2{b3_out}};
    assign q4 = {2{taps[base]}};

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_rise |=> ($stable(sel_q) && $stable(rng_q))); // R9
    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise |=> (rng_q == $past(range_sel) &&
                      sel_q == $past({bank3_sel, bank2_sel, bank1_sel}))); // R9

endmodule

// File: tb/test_prog_skew_clkgen.sv
// Self-checking bench: table-driven delay vectors, then directed tests for
// reset, divide modes and mid-pulse select changes.
module test_prog_skew_clkgen;

    localparam int HI = 60;
    localparam int LO = 60;

    typedef struct packed {
        logic [1:0] rng;
        logic [3:0] s1, s2, s3;
        logic [7:0] d1, d2, d3, d4;
    } vec_t;

    // L=00 M=01 H=10 float=11; tU = 4/3/2 for LOW/MID/HIGH
    localparam vec_t VEC [8] = '{
        '{2'b01, 4'b0101, 4'b0101, 4'b0101, 8'd18, 8'd18, 8'd18, 8'd18},
        '{2'b01, 4'b0000, 4'b1010, 4'b0001, 8'd6,  8'd30, 8'd0,  8'd18},
        '{2'b01, 4'b0001, 4'b1001, 4'b1001, 8'd9,  8'd27, 8'd36, 8'd18},
        '{2'b00, 4'b0010, 4'b0110, 4'b0010, 8'd16, 8'd28, 8'd8,  8'd24},
        '{2'b10, 4'b0100, 4'b1000, 4'b1000, 8'd10, 8'd16, 8'd20, 8'd12},
        '{2'b11, 4'b1111, 4'b1110, 4'b0111, 8'd18, 8'd21, 8'd18, 8'd18},
        '{2'b00, 4'b0101, 4'b0100, 4'b0110, 8'd24, 8'd20, 8'd32, 8'd24},
        '{2'b10, 4'b1010, 4'b0000, 4'b0100, 8'd20, 8'd4,  8'd8,  8'd12}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0;
    logic [1:0] range_sel = 2'b01;
    logic [3:0] bank1_sel = 4'b0101, bank2_sel = 4'b0101, bank3_sel = 4'b0101;
    logic [1:0] q1, q2, q3, q4;

    int checks = 0;
    int fails = 0;
    int rise_k [8];
    int fall_k [8];
    int nrise  [8];
    logic [1:0] pend_rng;
    logic [3:0] pend_s1;

    always #4 clk = ~clk;   // 125 MHz

    prog_skew_clkgen i_prog_skew_clkgen (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .range_sel(range_sel),
        .bank1_sel(bank1_sel), .bank2_sel(bank2_sel), .bank3_sel(bank3_sel),
        .q1(q1), .q2(q2), .q3(q3), .q4(q4)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One reference pulse from a falling clock edge; records first high/low sample per output bit.
    task automatic run_pulse(input bit chg);
        logic [7:0] q, prev;
        prev = {q4, q3, q2, q1};
        for (int b = 0; b < 8; b++) begin
            rise_k[b] = -1; fall_k[b] = -1; nrise[b] = 0;
        end
        ref_in = 1'b1;
        for (int k = 0; k < HI + LO; k++) begin
            @(negedge clk);
            if (chg && k == 0) begin
                range_sel = pend_rng;
                bank1_sel = pend_s1;
            end
            q = {q4, q3, q2, q1};
            for (int b = 0; b < 8; b++) begin
                if (q[b] && !prev[b]) nrise[b]++;
                if (rise_k[b] < 0 && q[b]) rise_k[b] = k;
                else if (rise_k[b] >= 0 && fall_k[b] < 0 && !q[b]) fall_k[b] = k;
            end
            prev = q;
            if (k == HI - 1) ref_in = 1'b0;
        end
    endtask

    task automatic chk_bank(input int bank, input int d, input string req);
        int lo;
        lo = 2 * bank;
        chk(rise_k[lo] == d, req, rise_k[lo], d);
        chk(fall_k[lo] == HI + d, "R11", fall_k[lo], HI + d);
        chk(rise_k[lo + 1] == rise_k[lo] && fall_k[lo + 1] == fall_k[lo], "R8",
            rise_k[lo + 1], rise_k[lo]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int tot;
        bit ok;
        // R10: outputs stay low in reset even with the reference high
        @(negedge clk);
        ref_in = 1'b1;
        repeat (40) begin
            @(negedge clk);
            chk({q4, q3, q2, q1} == 8'h00, "R10", {q4, q3, q2, q1}, 0);
        end
        ref_in = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({q4, q3, q2, q1} == 8'h00, "R10", {q4, q3, q2, q1}, 0);

        // Table of tap and range vectors
        for (int i = 0; i < 8; i++) begin
            range_sel = VEC[i].rng;
            bank1_sel = VEC[i].s1;
            bank2_sel = VEC[i].s2;
            bank3_sel = VEC[i].s3;
            run_pulse(1'b0);
            chk_bank(0, VEC[i].d1, (i == 5) ? "R1" : "R2");
            chk_bank(1, VEC[i].d2, (i == 5) ? "R1" : "R2");
            chk_bank(2, VEC[i].d3, "R3");
            chk_bank(3, VEC[i].d4, "R6 R7");
        end

        // R9: change during a pulse keeps old timing; next pulse uses new
        range_sel = 2'b01; bank1_sel = 4'b0101; bank2_sel = 4'b0101; bank3_sel = 4'b0101;
        pend_rng = 2'b00; pend_s1 = 4'b1010;
        run_pulse(1'b1);
        chk(rise_k[0] == 18 && fall_k[0] == HI + 18, "R9", rise_k[0], 18);
        chk(rise_k[6] == 18, "R9", rise_k[6], 18);
        run_pulse(1'b0);
        chk(rise_k[0] == 40, "R9", rise_k[0], 40);
        chk(rise_k[6] == 24, "R9", rise_k[6], 24);

        // R4: divide by 2 on bank 3 (MID range, base 18 cycles)
        range_sel = 2'b01; bank1_sel = 4'b0101; bank3_sel = 4'b0000;
        run_pulse(1'b0);
        tot = 0; ok = 1'b1;
        for (int p = 0; p < 8; p++) begin
            run_pulse(1'b0);
            tot += nrise[4];
            if (nrise[4] > 0 && rise_k[4] != 18 && fall_k[4] != 18) ok = 1'b0;
            if (nrise[5] != nrise[4]) ok = 1'b0;
        end
        chk(tot == 4, "R4", tot, 4);
        chk(ok, "R4", ok, 1);

        // R5: divide by 4 on bank 3
        bank3_sel = 4'b1010;
        run_pulse(1'b0);
        tot = 0; ok = 1'b1;
        for (int p = 0; p < 8; p++) begin
            run_pulse(1'b0);
            tot += nrise[4];
            if (nrise[4] > 1) ok = 1'b0;
            if (nrise[5] != nrise[4]) ok = 1'b0;
        end
        chk(tot == 2, "R5", tot, 2);
        chk(ok, "R5", ok, 1);

        finish_run();
    end

endmodule